// File: doc/BRIEF.md
# Serial Sponge Permutation Core

This block applies a selectable number of rounds of a 320-bit substitution-permutation function to a state supplied on its input. The state is handled as five 64-bit lanes. A single 5-bit S-box circuit is reused for every bit column: each clock cycle it reads bit j of all five lanes and writes the substituted five bits back into the same column. Each round has three parts. First a one-byte round constant is XORed into lane 2. Then the 64 columns are substituted one after another. Then all five lanes are diffused in a single cycle, each lane XORed with two rotated copies of itself.

A user offers a state and a round count with `in_valid`. The core accepts them on a rising edge where `in_ready` is high. `in_ready` then stays low until the result is available. There is no back-pressure on the output. `out_valid` is high for exactly one cycle, and `state_out` keeps the result until the next state is accepted. Because `in_ready` is already high in the `out_valid` cycle, a new state may be accepted on the very next edge. Any `in_valid` that arrives while the core is busy is dropped.

Top module: `sponge_perm_serial`

## Requirements
- R1: A state is taken only on a rising edge where both `in_valid` and `in_ready` are high. From the following cycle, `in_ready` is low until the result is delivered.
- R2: For an effective round count N, `out_valid` is high for exactly one cycle. It rises in the cycle that follows the 66·N-th rising edge after the accepting edge. Each round takes 1 constant cycle, 64 column cycles and 1 diffusion cycle.
- R3: A `rounds` value of 0, or any value above 12, runs 12 rounds. The values 1 to 12 run that many rounds.
- R4: Round index i (0..11) XORs the byte ((15−i)·16 + i) into the low byte of lane 2, which is `state_in[135:128]`. A run of N rounds uses the indices 12−N through 11, in that order.
- R5: Lane k occupies `state[319−64k -: 64]`. Column j forms the S-box input {x0[j],x1[j],x2[j],x3[j],x4[j]}, with x0 as the MSB. The S-box maps 0..31 to 4,b,1f,14,1a,15,9,2,1b,5,8,12,1d,3,6,1c,1e,13,7,e,0,d,11,18,10,c,1,19,16,a,f,17 (hex). The output is written back to the same column in the same bit order.
- R6: Diffusion replaces each lane x with x ^ ror(x,a) ^ ror(x,b). The rotation pairs (a,b) for lanes 0 to 4 are (19,28), (61,39), (1,6), (10,17) and (7,41).
- R7: While `in_ready` is low, `in_valid` and the values on `state_in` and `rounds` have no effect on the result or on its timing.
- R8: After reset, `in_ready` is high, `out_valid` is low and `state_out` is zero. While the core is idle, `state_out` holds the last result.
- R9: `in_ready` is high in the `out_valid` cycle. A state offered in that cycle is accepted on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A state and a round count are offered |
| in_ready | output | 1 | Core is idle and will accept an offer |
| rounds | input | 4 | Requested round count (0 or >12 means 12) |
| state_in | input | 320 | Input state, lane 0 in the top bits |
| out_valid | output | 1 | One-cycle pulse: result present |
| state_out | output | 320 | Working state; holds the result while idle |

## Verification
Each accepted state sets a countdown of 66·N edges in the bench model. `out_valid` and the result are expected in the cycle after the edge where that countdown reaches zero, and `in_ready` is expected high again in that same cycle. Every output is sampled on the falling edge and compared with the model, so an early or late pulse is caught in the cycle it happens. Offers made while the core is busy are ignored by the model. Runs are issued back to back, so the acceptance in the `out_valid` cycle is exercised as well.

// File: rtl/sp_pkg.sv
package sp_pkg;
  localparam int NLANES = 5;
  localparam int LANE_W = 64;
  localparam int STATE_W = NLANES * LANE_W;
  localparam int ROT_A [NLANES] = '{19, 61, 1, 10, 7};
  localparam int ROT_B [NLANES] = '{28, 39, 6, 17, 41};

  typedef logic [0:NLANES-1][LANE_W-1:0] state_t;

  typedef enum logic [1:0] {PH_IDLE, PH_CONST, PH_COLS, PH_DIFF} phase_t;

  function automatic logic [4:0] sbox_lut(input logic [4:0] v);
    logic [4:0] r;
    case (v)
      5'd0:  r = 5'h04; 5'd1:  r = 5'h0b; 5'd2:  r = 5'h1f; 5'd3:  r = 5'h14;
      5'd4:  r = 5'h1a; 5'd5:  r = 5'h15; 5'd6:  r = 5'h09; 5'd7:  r = 5'h02;
      5'd8:  r = 5'h1b; 5'd9:  r = 5'h05; 5'd10: r = 5'h08; 5'd11: r = 5'h12;
      5'd12: r = 5'h1d; 5'd13: r = 5'h03; 5'd14: r = 5'h06; 5'd15: r = 5'h1c;
      5'd16: r = 5'h1e; 5'd17: r = 5'h13; 5'd18: r = 5'h07; 5'd19: r = 5'h0e;
      5'd20: r = 5'h00; 5'd21: r = 5'h0d; 5'd22: r = 5'h11; 5'd23: r = 5'h18;
      5'd24: r = 5'h10; 5'd25: r = 5'h0c; 5'd26: r = 5'h01; 5'd27: r = 5'h19;
      5'd28: r = 5'h16; 5'd29: r = 5'h0a; 5'd30: r = 5'h0f; default: r = 5'h17;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/sp_sbox5.sv
module sp_sbox5 (
  input  logic [4:0] col_in,
  output logic [4:0] col_out
);
  always_comb col_out = sp_pkg::sbox_lut(col_in);
endmodule

// File: rtl/sp_diffuse.sv
module sp_diffuse
  import sp_pkg::*;
(
  input  state_t lanes_in,
  output state_t lanes_out
);
  for (genvar g = 0; g < NLANES; g++) begin : g_lane
    localparam int RA = ROT_A[g];
    localparam int RB = ROT_B[g];
    logic [LANE_W-1:0] w;
    assign w = lanes_in[g];
    assign lanes_out[g] = w ^ {w[RA-1:0], w[LANE_W-1:RA]} ^ {w[RB-1:0], w[LANE_W-1:RB]};
  end
endmodule

// File: rtl/sp_ctrl.sv
module sp_ctrl
  import sp_pkg::*;
#(
  parameter int ROUNDS_MAX = 12,
  parameter int COLS = LANE_W,
  localparam int RC_W = $clog2(ROUNDS_MAX + 1),
  localparam int COL_W = $clog2(COLS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [RC_W-1:0]  rounds,
  output logic             in_ready,
  output logic             load,
  output logic             add_rc,
  output logic             col_en,
  output logic             diff_en,
  output logic [COL_W-1:0] col,
  output logic [7:0]       rc_byte,
  output logic             done
);
  localparam logic [RC_W-1:0] RMAX = RC_W'(ROUNDS_MAX);
  localparam logic [COL_W-1:0] COL_LAST = COL_W'(COLS - 1);

  phase_t           phase;
  logic [RC_W-1:0]  rnd;
  logic [RC_W-1:0]  eff;
  logic             last_rnd;

  always_comb begin
    eff = (rounds == '0 || rounds > RMAX) ? RMAX : rounds;
    last_rnd = (rnd == RMAX - RC_W'(1));
    in_ready = (phase == PH_IDLE);
    load     = in_ready && in_valid;
    add_rc   = (phase == PH_CONST);
    col_en   = (phase == PH_COLS);
    diff_en  = (phase == PH_DIFF);
    rc_byte  = {4'(4'hf - 4'(rnd)), 4'(rnd)};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      rnd   <= '0;
      col   <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (phase)
        PH_IDLE: if (in_valid) begin
          rnd   <= RMAX - eff;
          phase <= PH_CONST;
        end
        PH_CONST: begin
          col   <= '0;
          phase <= PH_COLS;
        end
        PH_COLS: begin
          col <= col + COL_W'(1);
          if (col == COL_LAST) phase <= PH_DIFF;
        end
        PH_DIFF: begin
          if (last_rnd) begin
            phase <= PH_IDLE;
            done  <= 1'b1;
          end else begin
            rnd   <= rnd + RC_W'(1);
            phase <= PH_CONST;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sponge_perm_serial.sv
module sponge_perm_serial
  import sp_pkg::*;
#(
  parameter int ROUNDS_MAX = 12,
  localparam int RC_W = $clog2(ROUNDS_MAX + 1),
  localparam int COL_W = $clog2(LANE_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [RC_W-1:0]    rounds,
  input  logic [STATE_W-1:0] state_in,
  output logic               out_valid,
  output logic [STATE_W-1:0] state_out
);
  state_t           st;
  state_t           st_diff;
  logic             load, add_rc, col_en, diff_en;
  logic [COL_W-1:0] col;
  logic [7:0]       rc_byte;
  logic [4:0]       sb_in, sb_out;

  sp_ctrl #(.ROUNDS_MAX(ROUNDS_MAX), .COLS(LANE_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .rounds(rounds),
    .in_ready(in_ready), .load(load), .add_rc(add_rc), .col_en(col_en),
    .diff_en(diff_en), .col(col), .rc_byte(rc_byte), .done(out_valid)
  );

  always_comb begin
    for (int k = 0; k < NLANES; k++) sb_in[NLANES-1-k] = st[k][col];
  end

  sp_sbox5 u_sbox (.col_in(sb_in), .col_out(sb_out));

  sp_diffuse u_diff (.lanes_in(st), .lanes_out(st_diff));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= '0;
    end else if (load) begin
      st <= state_t'(state_in);
    end else if (add_rc) begin
      st[2][7:0] <= st[2][7:0] ^ rc_byte;
    end else if (col_en) begin
      for (int k = 0; k < NLANES; k++) st[k][col] <= sb_out[NLANES-1-k];
    end else if (diff_en) begin
      st <= st_diff;
    end
  end

  assign state_out = STATE_W'(st);
endmodule

// File: rtl/sp_perm_chk.sv
module sp_perm_chk #(
  parameter int ROUNDS_MAX = 12,
  localparam int RC_W = $clog2(ROUNDS_MAX + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [RC_W-1:0]  rounds,
  input logic             out_valid,
  input logic [319:0]     state_out
);
  logic [15:0] lat;
  logic [15:0] want;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat  <= '0;
      want <= '0;
    end else if (in_valid && in_ready) begin
      lat  <= '0;
      want <= 16'(66) * ((rounds == '0 || rounds > RC_W'(ROUNDS_MAX)) ? 16'(ROUNDS_MAX) : 16'(rounds));
    end else if (!in_ready) begin
      lat <= lat + 16'd1;
    end
  end

  p_accept_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);
  p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  p_done_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (lat == want && want != 16'd0));
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid) |=> $stable(state_out));
  p_ready_on_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> in_ready);
endmodule

bind sponge_perm_serial sp_perm_chk #(.ROUNDS_MAX(ROUNDS_MAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .rounds(rounds), .out_valid(out_valid), .state_out(state_out)
);

// File: tb/sponge_perm_serial_tb.sv
module sponge_perm_serial_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [3:0]   rounds = '0;
  logic [319:0] state_in = '0;
  logic         out_valid;
  logic [319:0] state_out;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  sponge_perm_serial u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .rounds(rounds), .state_in(state_in), .out_valid(out_valid), .state_out(state_out)
  );

  function automatic logic [63:0] ror(input logic [63:0] x, input int n);
    return (x >> n) | (x << (64 - n));
  endfunction

  function automatic int eff_rounds(input logic [3:0] r);
    return (r == 0 || r > 12) ? 12 : int'(r);
  endfunction

  // behavioural reference: whole-lane boolean form of the S-box (R5), rotations (R6), constants (R4)
  function automatic logic [319:0] ref_perm(input logic [319:0] s, input int n);
    logic [63:0] x [5];
    logic [63:0] t [5];
    int ra [5] = '{19, 61, 1, 10, 7};
    int rb [5] = '{28, 39, 6, 17, 41};
    for (int k = 0; k < 5; k++) x[k] = s[319 - 64*k -: 64];
    for (int i = 12 - n; i < 12; i++) begin
      x[2][7:0] = x[2][7:0] ^ 8'(((15 - i) << 4) | i);
      x[0] ^= x[4]; x[4] ^= x[3]; x[2] ^= x[1];
      for (int k = 0; k < 5; k++) t[k] = ~x[k] & x[(k + 1) % 5];
      for (int k = 0; k < 5; k++) x[k] ^= t[(k + 1) % 5];
      x[1] ^= x[0]; x[0] ^= x[4]; x[3] ^= x[2]; x[2] = ~x[2];
      for (int k = 0; k < 5; k++) x[k] = x[k] ^ ror(x[k], ra[k]) ^ ror(x[k], rb[k]);
    end
    return {x[0], x[1], x[2], x[3], x[4]};
  endfunction

  // cycle model
  bit           m_busy = 0;
  bit           m_done = 0;
  int           m_left = 0;
  logic [319:0] m_exp = '0;
  logic [319:0] m_out = '0;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_left = 0; m_out = '0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        m_left--;
        if (m_left == 0) begin
          m_busy = 0; m_done = 1; m_out = m_exp;
        end
      end else if (in_valid) begin
        m_busy = 1;
        m_left = 66 * eff_rounds(rounds);
        m_exp  = ref_perm(state_in, eff_rounds(rounds));
      end
    end
  end

  task automatic check1(input bit ok, input string req, input logic [319:0] act, input logic [319:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", req, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      check1(in_ready == !m_busy, "R1 R7 in_ready", 320'(in_ready), 320'(!m_busy));
      check1(out_valid == m_done, "R2 R3 out_valid", 320'(out_valid), 320'(m_done));
      if (!m_busy)
        check1(state_out == m_out, "R4 R5 R6 R8 state_out", state_out, m_out);
    end
  end

  function automatic logic [319:0] rnd320();
    logic [319:0] v;
    for (int i = 0; i < 10; i++) v[32*i +: 32] = $urandom();
    return v;
  endfunction

  task automatic offer(input logic [319:0] d, input logic [3:0] r);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; state_in = d; rounds = r;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_done();
    while (!out_valid) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    while (cyc < 150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [319:0] hold;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R8: reset state
    check1(in_ready === 1'b1 && out_valid === 1'b0 && state_out === '0, "R8 reset", state_out, '0);

    // R5 R4: all-zero state, full run
    offer('0, 4'd12); wait_done();
    // R2: single round, then mid counts
    offer(rnd320(), 4'd1); wait_done();
    offer(rnd320(), 4'd6); wait_done();
    offer({5{64'h0123456789abcdef}}, 4'd8); wait_done();
    // R3: out-of-range counts
    offer(rnd320(), 4'd0); wait_done();
    offer(rnd320(), 4'd15); wait_done();
    offer(rnd320(), 4'd13); wait_done();
    // R7: offers during busy are dropped
    offer(rnd320(), 4'd3);
    repeat (30) @(negedge clk);
    in_valid = 1'b1; state_in = rnd320(); rounds = 4'd1;
    repeat (5) @(negedge clk);
    in_valid = 1'b0;
    wait_done();
    // R9: offer in the done cycle, held valid across it
    hold = rnd320();
    in_valid = 1'b1; state_in = hold; rounds = 4'd2;
    @(negedge clk);
    in_valid = 1'b0;
    check1(in_ready == 1'b0, "R9 accepted in done cycle", 320'(in_ready), 320'(0));
    wait_done();
    check1(state_out == ref_perm(hold, 2), "R9 result", state_out, ref_perm(hold, 2));
    // R8: idle hold
    repeat (40) @(negedge clk);
    check1(state_out == ref_perm(hold, 2), "R8 hold", state_out, ref_perm(hold, 2));
    finish_run();
  end
endmodule